// File: doc/BRIEF.md
# Codec Bus Master Clock Gater

This block is the master-side timing source for a synchronous PCM codec serial bus. It divides the fast system clock down to a bit clock and numbers the bit periods of each frame with a counter that wraps at a programmed frame length. At count zero it raises a frame-sync pulse one bit period wide. Within every frame, a programmable window of bit periods holds the bit clock at logic 0. The frame counter keeps running through that window, so fewer clock pulses than bit periods reach the bus in each frame.

A small transmit shifter sits beside the timer and sends one word per load on the chosen bit-clock edge. It exists so that the quiet window can be checked against real traffic. A flag tells the data source when shifting is still permitted in the current frame. If the quiet window opens while bits are still waiting to go out, a sticky error flag is raised. All timing settings are captured only at frame boundaries, so a change made part-way through a frame first affects the next one.

Top module: `pcm_frame_clkgen`

## Requirements
- R1: One bit period lasts 2*(cfg_div+1) system clocks. The bit clock is low for the first half of the period and high for the second, and `frame_cnt` advances by one at the end of each bit period.
- R2: `frame_cnt` counts from 0 up to cfg_frame_len-1 and then returns to 0. A frame length below 2 behaves as 2.
- R3: The frame sync is active for exactly the bit period in which `frame_cnt` is 0. Active means high when cfg_invert is 0 and low when cfg_invert is 1.
- R4: The quiet window is valid when idle-start < idle-end <= frame length. When it is valid, `bclk` stays 0 for every bit period whose count lies in [idle-start, idle-end), and a frame carries frame_len-(idle_end-idle_start) bit-clock pulses. Example: frame 100, start 60, end 90 gives 70 pulses.
- R5: When idle-start >= idle-end, or idle-end > frame length, no window is applied and every frame carries frame_len pulses.
- R6: The divider, frame length, window bounds, edge select and inversion are sampled in the first cycle after reset and again when the counter wraps. A frame already in progress keeps the old values.
- R7: `tx_allowed` is 1 when no valid window exists or when `frame_cnt` < idle-start. It is 0 otherwise.
- R8: A `tx_load` pulse takes `tx_word` and sends it MSB first. Each active bit-clock edge moves to the next bit: the rising edge when cfg_fall_edge is 0, the falling edge when it is 1. Suppressed edges inside the window do not shift. Between words the line rests at 0. With cfg_invert set, every level on `tx_dout` is inverted.
- R9: `tx_err` is set when the quiet window opens while bits of the current word remain unsent. It stays set until the next `tx_load`.
- R10: During reset `bclk`, `frame_cnt`, `tx_dout` and `tx_err` are 0 and the frame sync is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Half bit period in system clocks, minus one |
| cfg_frame_len | input | CNT_W | Frame length in bit periods |
| cfg_idle_start | input | CNT_W | Count at which the quiet window opens |
| cfg_idle_end | input | CNT_W | Count at which the quiet window closes |
| cfg_fall_edge | input | 1 | 1 selects the falling edge as the active edge |
| cfg_invert | input | 1 | Inverts frame sync and transmit data levels |
| tx_load | input | 1 | Loads a new transmit word |
| tx_word | input | DATA_W | Word to transmit, MSB first |
| bclk | output | 1 | Gated bit clock |
| fsync | output | 1 | Frame sync |
| frame_cnt | output | CNT_W | Bit-period index within the frame |
| tx_allowed | output | 1 | Shifting is permitted in this bit period |
| tx_dout | output | 1 | Serial transmit data |
| tx_err | output | 1 | Sticky flag for a word cut off by the quiet window |

## Verification
The embedded properties are checked on every cycle. They cover: the frame counter staying in range and moving only at bit ends; the shadowed settings holding still except at a wrap; `tx_allowed` never being set inside the window; the bit clock being held low through the window; the shifter dropping at most one bit per cycle; and the error flag rising only at the entry to the window. Some results only the scenarios can show: the pulse count of whole frames, the sync width and polarity, the order and inversion of the transmitted bits on each edge choice, and a mid-frame setting change being deferred to the next frame. The bench measures these at the ports against values computed from the settings it applied.

// File: rtl/pcm_clkgen_pkg.sv
package pcm_clkgen_pkg;

  // Last count value of a frame; lengths under two are treated as two.
  function automatic int unsigned frame_last(int unsigned len);
    return (len < 2) ? 1 : len - 1;
  endfunction

  // A quiet window exists only when it is non-empty and fits in the frame.
  function automatic bit window_ok(int unsigned s, int unsigned e, int unsigned len);
    return (s < e) && (e <= len);
  endfunction

  // True when bit period `cnt` falls inside the quiet window.
  function automatic bit in_quiet(int unsigned cnt, int unsigned s, int unsigned e,
                                  int unsigned len);
    return window_ok(s, e, len) && (cnt >= s) && (cnt < e);
  endfunction

endpackage

// File: rtl/pcm_bit_divider.sv
module pcm_bit_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,
  output logic             phase,
  output logic             rise_tick,
  output logic             bit_end
);
  logic [DIV_W-1:0] half_cnt;
  logic             tick;

  assign tick      = run && (half_cnt == half_len);
  assign rise_tick = tick && !phase;
  assign bit_end   = tick && phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      phase    <= 1'b0;
    end else if (run) begin
      if (tick) begin
        half_cnt <= '0;
        phase    <= ~phase;
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end

  // R1
  half_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (half_cnt <= half_len));

  // R1
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(phase));

endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq
  import pcm_clkgen_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_end,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [CNT_W-1:0] cfg_len,
  input  logic [CNT_W-1:0] cfg_start,
  input  logic [CNT_W-1:0] cfg_end,
  input  logic             cfg_fall,
  input  logic             cfg_inv,
  output logic             loaded,
  output logic [DIV_W-1:0] sh_div,
  output logic             sh_fall,
  output logic             sh_inv,
  output logic [CNT_W-1:0] frame_cnt,
  output logic             idle,
  output logic             tx_ok,
  output logic             fsync
);
  logic [CNT_W-1:0] sh_len, sh_start, sh_end;
  logic             wrap, take;

  assign wrap = bit_end && (frame_cnt == CNT_W'(frame_last(32'(sh_len))));
  assign take = !loaded || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded   <= 1'b0;
      sh_div   <= '0;
      sh_len   <= '0;
      sh_start <= '0;
      sh_end   <= '0;
      sh_fall  <= 1'b0;
      sh_inv   <= 1'b0;
    end else if (take) begin
      loaded   <= 1'b1;
      sh_div   <= cfg_div;
      sh_len   <= cfg_len;
      sh_start <= cfg_start;
      sh_end   <= cfg_end;
      sh_fall  <= cfg_fall;
      sh_inv   <= cfg_inv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             frame_cnt <= '0;
    else if (wrap)          frame_cnt <= '0;
    else if (bit_end)       frame_cnt <= frame_cnt + 1'b1;
  end

  assign idle  = in_quiet(32'(frame_cnt), 32'(sh_start), 32'(sh_end), 32'(sh_len));
  assign tx_ok = !window_ok(32'(sh_start), 32'(sh_end), 32'(sh_len)) ||
                 (frame_cnt < sh_start);
  assign fsync = (frame_cnt == '0) ^ sh_inv;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |-> (32'(frame_cnt) <= frame_last(32'(sh_len))));

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !bit_end) |=> $stable(frame_cnt));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !wrap) |=> ($stable(sh_len) && $stable(sh_start) && $stable(sh_end)
                           && $stable(sh_div) && $stable(sh_inv) && $stable(sh_fall)));

  // R7
  tx_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !tx_ok);

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  input  logic              edge_evt,
  input  logic              idle,
  input  logic              inv,
  output logic              dout,
  output logic              err
);
  localparam int LEFT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shreg;
  logic [LEFT_W-1:0] left;
  logic              idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      left   <= '0;
      idle_q <= 1'b0;
      err    <= 1'b0;
    end else begin
      idle_q <= idle;
      if (load) begin
        shreg <= word;
        left  <= LEFT_W'(DATA_W);
        err   <= 1'b0;
      end else begin
        if (edge_evt && (left != '0)) begin
          shreg <= {shreg[DATA_W-2:0], 1'b0};
          left  <= left - 1'b1;
        end
        if (idle && !idle_q && (left != '0)) err <= 1'b1;
      end
    end
  end

  assign dout = ((left != '0) ? shreg[DATA_W-1] : 1'b0) ^ inv;

  // R8
  left_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left <= LEFT_W'(DATA_W));

  // R8
  left_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((left == $past(left)) || (left == $past(left) - 1'b1)));

  // R9
  err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(idle) && !$past(idle_q)));

endmodule

// File: rtl/pcm_frame_clkgen.sv
module pcm_frame_clkgen #(
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [CNT_W-1:0]  cfg_frame_len,
  input  logic [CNT_W-1:0]  cfg_idle_start,
  input  logic [CNT_W-1:0]  cfg_idle_end,
  input  logic              cfg_fall_edge,
  input  logic              cfg_invert,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_word,
  output logic              bclk,
  output logic              fsync,
  output logic [CNT_W-1:0]  frame_cnt,
  output logic              tx_allowed,
  output logic              tx_dout,
  output logic              tx_err
);
  logic             loaded, phase, rise_tick, bit_end, idle;
  logic             sh_fall, sh_inv, edge_evt;
  logic [DIV_W-1:0] sh_div;

  pcm_bit_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(loaded), .half_len(sh_div),
    .phase(phase), .rise_tick(rise_tick), .bit_end(bit_end)
  );

  pcm_frame_seq #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .bit_end(bit_end),
    .cfg_div(cfg_div), .cfg_len(cfg_frame_len), .cfg_start(cfg_idle_start),
    .cfg_end(cfg_idle_end), .cfg_fall(cfg_fall_edge), .cfg_inv(cfg_invert),
    .loaded(loaded), .sh_div(sh_div), .sh_fall(sh_fall), .sh_inv(sh_inv),
    .frame_cnt(frame_cnt), .idle(idle), .tx_ok(tx_allowed), .fsync(fsync)
  );

  // Bus-visible clock and the edge the shifter acts on; both vanish in the window.
  assign bclk     = phase & ~idle;
  assign edge_evt = ~idle & (sh_fall ? bit_end : rise_tick);

  pcm_tx_shifter #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .word(tx_word),
    .edge_evt(edge_evt), .idle(idle), .inv(sh_inv),
    .dout(tx_dout), .err(tx_err)
  );

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !bit_end) |=> !bclk);

endmodule

// File: tb/sim_pcm_frame_clkgen.sv
module sim_pcm_frame_clkgen;
  localparam int CNT_W = 8, DIV_W = 8, DATA_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0]  cfg_div;
  logic [CNT_W-1:0]  cfg_frame_len, cfg_idle_start, cfg_idle_end;
  logic              cfg_fall_edge, cfg_invert, tx_load;
  logic [DATA_W-1:0] tx_word;
  logic bclk, fsync, tx_allowed, tx_dout, tx_err;
  logic [CNT_W-1:0]  frame_cnt;

  always #2 clk = ~clk;

  pcm_frame_clkgen #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_frame_len(cfg_frame_len),
    .cfg_idle_start(cfg_idle_start), .cfg_idle_end(cfg_idle_end),
    .cfg_fall_edge(cfg_fall_edge), .cfg_invert(cfg_invert), .tx_load(tx_load),
    .tx_word(tx_word), .bclk(bclk), .fsync(fsync), .frame_cnt(frame_cnt),
    .tx_allowed(tx_allowed), .tx_dout(tx_dout), .tx_err(tx_err)
  );

  typedef struct {
    int    frame;
    int    pulses;
    int    fs_cycles;
    int    max_cnt;
    bit    inv;
    string tag;
  } frame_exp_t;

  frame_exp_t fq[$];
  bit         bq[$];
  int checks = 0, fails = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected frame figures, worked out from the settings alone.
  function automatic frame_exp_t mk(int fr, int d, int l, int s, int e, bit i, string tag);
    frame_exp_t x;
    int quiet;
    quiet = 0;
    if (e > s && l >= e) quiet = e - s;
    x.frame = fr; x.pulses = l - quiet; x.fs_cycles = 2 * d + 2;
    x.max_cnt = l - 1; x.inv = i; x.tag = tag;
    return x;
  endfunction

  // Monitor
  int   frame_idx = 0, pulse_ctr = 0, hi_ctr = 0, lo_ctr = 0, max_ctr = 0;
  logic prev_bclk = 1'b0, prev_dout = 1'b0;
  logic [CNT_W-1:0] prev_cnt = '0;
  bit   mon_fall = 1'b0, mon_inv = 1'b0, mon_on = 1'b0;
  event frame_ev;

  always @(negedge clk) begin
    frame_exp_t x;
    bit e, fresh;
    if (mon_on) begin
      fresh = 1'b0;
      if ((mon_fall && prev_bclk && !bclk) || (!mon_fall && !prev_bclk && bclk)) begin
        if (bq.size() > 0) begin
          e = bq.pop_front();
          check(prev_dout == e, "R8", "data bit", int'(prev_dout), int'(e));
        end
      end
      if (!prev_bclk && bclk) pulse_ctr++;
      if (frame_cnt == '0 && prev_cnt != '0) begin
        while (fq.size() > 0 && fq[0].frame < frame_idx) begin
          x = fq.pop_front();
          check(1'b0, "R6", "frame item not seen", x.frame, frame_idx);
        end
        if (fq.size() > 0 && fq[0].frame == frame_idx) begin
          x = fq.pop_front();
          check(pulse_ctr == x.pulses, x.tag, "bclk pulses per frame", pulse_ctr, x.pulses);
          check((x.inv ? lo_ctr : hi_ctr) == x.fs_cycles, "R1", "sync width in clocks",
                x.inv ? lo_ctr : hi_ctr, x.fs_cycles);
          check(max_ctr == x.max_cnt, "R2", "last frame count", max_ctr, x.max_cnt);
        end
        frame_idx++;
        pulse_ctr = 0; hi_ctr = 0; lo_ctr = 0; max_ctr = 0;
        fresh = 1'b1;
      end
      if (fsync) hi_ctr++; else lo_ctr++;
      if (int'(frame_cnt) > max_ctr) max_ctr = int'(frame_cnt);
      prev_bclk = bclk; prev_dout = tx_dout; prev_cnt = frame_cnt;
      if (fresh) -> frame_ev;
    end
  end

  // Driver
  int l_div = 1, l_len = 100, l_st = 60, l_en = 90;
  bit l_inv = 1'b0;

  task automatic apply(int d, int l, int s, int e, bit f, bit i, int n, string tag);
    while (frame_cnt != CNT_W'(2)) @(negedge clk);
    fq.push_back(mk(frame_idx, l_div, l_len, l_st, l_en, l_inv, "R6"));
    cfg_div = DIV_W'(d); cfg_frame_len = CNT_W'(l); cfg_idle_start = CNT_W'(s);
    cfg_idle_end = CNT_W'(e); cfg_fall_edge = f; cfg_invert = i;
    l_div = d; l_len = l; l_st = s; l_en = e; l_inv = i;
    for (int k = 1; k <= n; k++) fq.push_back(mk(frame_idx + k, d, l, s, e, i, tag));
    repeat (n + 1) @(frame_ev);
    mon_fall = f; mon_inv = i;
  endtask

  task automatic send_word(logic [DATA_W-1:0] w, bit expect_bits);
    @(frame_ev);
    tx_word = w; tx_load = 1'b1;
    if (expect_bits)
      for (int b = DATA_W - 1; b >= 0; b--) bq.push_back(w[b] ^ mon_inv);
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit quiet_ok;
    cfg_div = 8'd1; cfg_frame_len = 8'd100; cfg_idle_start = 8'd60; cfg_idle_end = 8'd90;
    cfg_fall_edge = 1'b0; cfg_invert = 1'b0; tx_load = 1'b0; tx_word = '0;
    repeat (4) @(negedge clk);
    // R10: reset state
    check(bclk == 1'b0, "R10", "bclk in reset", int'(bclk), 0);
    check(frame_cnt == '0, "R10", "frame_cnt in reset", int'(frame_cnt), 0);
    check(tx_err == 1'b0, "R10", "tx_err in reset", int'(tx_err), 0);
    check(tx_dout == 1'b0, "R10", "tx_dout in reset", int'(tx_dout), 0);
    check(fsync == 1'b1, "R10", "fsync in reset", int'(fsync), 1);
    rst_n = 1'b1; mon_on = 1'b1;

    // R4: worked example, 70 pulses in a 100-period frame
    @(frame_ev);
    apply(1, 100, 60, 90, 1'b0, 1'b0, 2, "R4");
    send_word(16'hA5C3, 1'b1);
    repeat (2) @(frame_ev);
    check(bq.size() == 0, "R8", "rising-edge word fully sent", bq.size(), 0);
    check(tx_dout == 1'b0, "R8", "rest level", int'(tx_dout), 0);
    check(tx_err == 1'b0, "R9", "no error for short word", int'(tx_err), 0);

    // R5: empty window, falling edge, inverted levels
    apply(2, 40, 10, 10, 1'b1, 1'b1, 2, "R5");
    while (frame_cnt != CNT_W'(5)) @(negedge clk);
    check(fsync == 1'b1, "R3", "inverted sync idle level", int'(fsync), 1);
    send_word(16'h3C96, 1'b1);
    repeat (2) @(frame_ev);
    check(bq.size() == 0, "R8", "falling-edge word fully sent", bq.size(), 0);
    check(tx_dout == 1'b1, "R8", "inverted rest level", int'(tx_dout), 1);

    // R5: window end past the frame length
    apply(1, 30, 5, 40, 1'b0, 1'b0, 2, "R5");
    check(fsync == 1'b1, "R3", "sync active at count 0", int'(fsync), 1);

    // R9: word too long for the span before the window
    apply(1, 24, 10, 20, 1'b0, 1'b0, 1, "R4");
    send_word(16'hFFFF, 1'b0);
    while (frame_cnt != CNT_W'(9)) @(negedge clk);
    check(tx_allowed == 1'b1, "R7", "allowed before window", int'(tx_allowed), 1);
    while (frame_cnt != CNT_W'(10)) @(negedge clk);
    check(tx_allowed == 1'b0, "R7", "blocked at window start", int'(tx_allowed), 0);
    quiet_ok = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (bclk) quiet_ok = 1'b0;
    end
    check(quiet_ok, "R4", "bclk low inside window", int'(quiet_ok), 1);
    check(tx_err == 1'b1, "R9", "error at window entry", int'(tx_err), 1);
    while (frame_cnt != CNT_W'(21)) @(negedge clk);
    check(tx_allowed == 1'b0, "R7", "blocked after window", int'(tx_allowed), 0);
    send_word(16'h0001, 1'b0);
    repeat (2) @(negedge clk);
    check(tx_err == 1'b0, "R9", "error cleared by load", int'(tx_err), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule